// File: doc/BRIEF.md
# Segmented Oscillator Tuning Word Controller

This block turns the digital frequency command of a phase-locked loop into switch settings for a capacitor-tuned oscillator. The capacitance is split into two banks. The coarse bank is binary weighted. It follows a coarse word only while an acquisition flag is raised, and it keeps its setting once the flag drops. The fine bank is a row of equal unit capacitors. It takes a thermometer code, so that more control word always means more capacitance.

The fine command is an unsigned fixed-point number. Its upper bits give a whole number of unit elements. Its lower bits give a fraction of one element. That fraction drives a first-order error-feedback accumulator. The accumulator runs in a fast dither clock domain at M times the reference rate. Each carry out of the accumulator switches on one extra element for that dither cycle. The time-averaged capacitance therefore resolves steps finer than one element.

Fine words enter in the reference domain over a valid/ready interface. A word is accepted on a reference edge where both fine_valid and fine_ready are high. fine_ready then stays low while the word crosses into the dither domain through a toggle handshake. The sender must hold fine_word stable whenever fine_valid is high and fine_ready is low. The divider that makes the reference clock from the dither clock is outside this block, and so is the oscillator tank.

Top module: `dco_tune_ctrl`

## Requirements
- R1: While rst_n is low, and right after it is released, coarse_sel is all zeros, fine_therm is all zeros and fine_ready is 1.
- R2: When acq_en is 1 on a rising ref_clk edge, coarse_word is captured on that edge and appears on coarse_sel until the next ref_clk edge.
- R3: When acq_en is 0 on a rising ref_clk edge, coarse_sel keeps its value on that edge, whatever coarse_word is.
- R4: After a word is accepted, fine_ready is 0 in the next ref_clk cycle. It returns to 1 only once the word is held in the dither domain.
- R5: fine_therm is a thermometer code. Bit i is 1 exactly when the element count for that dither cycle exceeds i, so its ones are contiguous from bit 0.
- R6: The upper INT_W bits of fine_word are the integer part and the lower FRAC_W bits are the fraction. With a zero fraction, every dither cycle switches on exactly min(integer, NUNITS) elements.
- R7: With fraction f, each dither cycle switches on either the integer part or the integer part plus one. Over any 2^FRAC_W consecutive dither cycles, exactly f of those cycles use the integer part plus one.
- R8: When the integer part plus the dither carry exceeds NUNITS, fine_therm is all ones for that dither cycle.
- R9: Once fine_ready has returned to 1, fine_therm follows the new word from the second following dither_clk edge onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference-rate clock for the coarse register and the fine word interface |
| dith_clk | input | 1 | Dither clock, M times the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| acq_en | input | 1 | High during initial frequency acquisition; enables coarse updates |
| coarse_word | input | COARSE_W | Requested coarse bank setting |
| fine_word | input | INT_W+FRAC_W | Fine command, integer part over fraction |
| fine_valid | input | 1 | fine_word holds a new command |
| fine_ready | output | 1 | The block can accept a fine command |
| coarse_sel | output | COARSE_W | Binary-weighted coarse bank switches |
| fine_therm | output | NUNITS | Unit-element fine bank switches, thermometer coded |

## Verification
Two events can land on the same reference edge: a coarse update during acquisition and the acceptance of a fine word. The bench provokes this by driving a new coarse word and a new fine word together with acq_en high. It then checks that coarse_sel takes the coarse value on that edge. It also checks that the fine bank settles to the pattern the new word predicts once the handshake completes, with neither path disturbing the other. In the dither domain, the loading of a new word can coincide with an accumulator carry. That case is judged by summing the count of lit elements over a full accumulator period.

// File: rtl/dco_tune_pkg.sv
package dco_tune_pkg;
  // default geometry of the banks
  localparam int unsigned DEF_COARSE_W = 6;
  localparam int unsigned DEF_NUNITS   = 12;
  localparam int unsigned DEF_INT_W    = 4;
  localparam int unsigned DEF_FRAC_W   = 4;

  // number of bits needed to hold a count up to and including n
  function automatic int unsigned count_bits(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/dco_coarse_reg.sv
module dco_coarse_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd_en,
  input  logic [W-1:0] word_in,
  output logic [W-1:0] word_q
);
  // the coarse bank moves only while acquisition is in progress
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      word_q <= '0;
    else if (upd_en) word_q <= word_in;
  end
endmodule

// File: rtl/dco_word_cdc.sv
module dco_word_cdc #(
  parameter int unsigned W = 8
) (
  input  logic         src_clk,
  input  logic         dst_clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_data,
  input  logic         src_valid,
  output logic         src_ready,
  output logic [W-1:0] dst_data
);
  localparam int unsigned SYNC_N = 2;

  logic               req_tgl;
  logic [W-1:0]       hold_q;
  logic [SYNC_N-1:0]  ack_sync;
  logic [SYNC_N:0]    req_sync;
  logic               ack_tgl;
  logic               take;

  assign src_ready = (req_tgl == ack_sync[SYNC_N-1]);
  assign take      = src_valid && src_ready;

  // source side: hold the word and flip the request
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tgl  <= 1'b0;
      hold_q   <= '0;
      ack_sync <= '0;
    end else begin
      ack_sync <= {ack_sync[SYNC_N-2:0], ack_tgl};
      if (take) begin
        hold_q  <= src_data;
        req_tgl <= ~req_tgl;
      end
    end
  end

  // destination side: two-stage synchronizer, edge detect, load, acknowledge
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_sync <= '0;
      ack_tgl  <= 1'b0;
      dst_data <= '0;
    end else begin
      req_sync <= {req_sync[SYNC_N-1:0], req_tgl};
      if (req_sync[SYNC_N] != req_sync[SYNC_N-1]) begin
        dst_data <= hold_q;
        ack_tgl  <= ~ack_tgl;
      end
    end
  end
endmodule

// File: rtl/dco_frac_mod.sv
module dco_frac_mod #(
  parameter int unsigned FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  // first-order error feedback: the residue stays in the accumulator
  assign sum   = {1'b0, acc_q} + {1'b0, frac};
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/dco_therm_drv.sv
module dco_therm_drv #(
  parameter int unsigned NUNITS = 12,
  parameter int unsigned INT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INT_W-1:0]  int_part,
  input  logic              extra,
  output logic [NUNITS-1:0] therm
);
  localparam int unsigned SUM_W = (INT_W + 1 > dco_tune_pkg::count_bits(NUNITS))
                                  ? INT_W + 1 : dco_tune_pkg::count_bits(NUNITS);
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(NUNITS);

  logic [SUM_W-1:0]  total;
  logic [SUM_W-1:0]  clipped;
  logic [NUNITS-1:0] therm_n;

  assign total   = SUM_W'(int_part) + SUM_W'(extra);
  assign clipped = (total > LIMIT) ? LIMIT : total;

  // element i is on whenever the count passes it
  for (genvar i = 0; i < NUNITS; i++) begin : g_unit
    assign therm_n[i] = (clipped > SUM_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) therm <= '0;
    else        therm <= therm_n;
  end
endmodule

// File: rtl/dco_tune_ctrl.sv
module dco_tune_ctrl #(
  parameter int unsigned COARSE_W = dco_tune_pkg::DEF_COARSE_W,
  parameter int unsigned NUNITS   = dco_tune_pkg::DEF_NUNITS,
  parameter int unsigned INT_W    = dco_tune_pkg::DEF_INT_W,
  parameter int unsigned FRAC_W   = dco_tune_pkg::DEF_FRAC_W
) (
  input  logic                      ref_clk,
  input  logic                      dith_clk,
  input  logic                      rst_n,
  input  logic                      acq_en,
  input  logic [COARSE_W-1:0]       coarse_word,
  input  logic [INT_W+FRAC_W-1:0]   fine_word,
  input  logic                      fine_valid,
  output logic                      fine_ready,
  output logic [COARSE_W-1:0]       coarse_sel,
  output logic [NUNITS-1:0]         fine_therm
);
  localparam int unsigned FINE_W = INT_W + FRAC_W;

  logic [FINE_W-1:0] fast_word;
  logic              dith_carry;

  dco_coarse_reg #(.W(COARSE_W)) u_coarse (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .upd_en  (acq_en),
    .word_in (coarse_word),
    .word_q  (coarse_sel)
  );

  dco_word_cdc #(.W(FINE_W)) u_cdc (
    .src_clk   (ref_clk),
    .dst_clk   (dith_clk),
    .rst_n     (rst_n),
    .src_data  (fine_word),
    .src_valid (fine_valid),
    .src_ready (fine_ready),
    .dst_data  (fast_word)
  );

  dco_frac_mod #(.FRAC_W(FRAC_W)) u_mod (
    .clk   (dith_clk),
    .rst_n (rst_n),
    .frac  (fast_word[FRAC_W-1:0]),
    .carry (dith_carry)
  );

  dco_therm_drv #(.NUNITS(NUNITS), .INT_W(INT_W)) u_therm (
    .clk      (dith_clk),
    .rst_n    (rst_n),
    .int_part (fast_word[FINE_W-1:FRAC_W]),
    .extra    (dith_carry),
    .therm    (fine_therm)
  );
endmodule

// File: rtl/dco_tune_chk.sv
module dco_tune_chk #(
  parameter int unsigned COARSE_W = 6,
  parameter int unsigned NUNITS   = 12,
  parameter int unsigned INT_W    = 4,
  parameter int unsigned FRAC_W   = 4
) (
  input logic                    ref_clk,
  input logic                    dith_clk,
  input logic                    rst_n,
  input logic                    acq_en,
  input logic                    fine_valid,
  input logic                    fine_ready,
  input logic [COARSE_W-1:0]     coarse_sel,
  input logic [NUNITS-1:0]       fine_therm,
  input logic [INT_W+FRAC_W-1:0] fast_word
);
  // R3: no coarse movement outside acquisition
  assert_coarse_frozen_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !acq_en |=> $stable(coarse_sel));

  // R4: ready drops after a word is taken
  assert_ready_drops_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (fine_valid && fine_ready) |=> !fine_ready);

  // R5: ones contiguous from bit zero
  assert_therm_shape_R5: assert property (@(posedge dith_clk) disable iff (!rst_n)
    ((({1'b0, fine_therm} + 1'b1) & {1'b0, fine_therm}) == '0));

  // R8: an integer part at or above the bank size lights every element
  assert_sat_full_R8: assert property (@(posedge dith_clk) disable iff (!rst_n)
    (fast_word[INT_W+FRAC_W-1:FRAC_W] >= INT_W'(NUNITS)) |=> (&fine_therm));

  // R6: no fraction means a steady count equal to the integer part
  assert_int_count_R6: assert property (@(posedge dith_clk) disable iff (!rst_n)
    ((fast_word[FRAC_W-1:0] == '0) && (fast_word[INT_W+FRAC_W-1:FRAC_W] < INT_W'(NUNITS)))
      |=> ($countones(fine_therm) == int'($past(fast_word[INT_W+FRAC_W-1:FRAC_W]))));
endmodule

bind dco_tune_ctrl dco_tune_chk #(
  .COARSE_W (COARSE_W),
  .NUNITS   (NUNITS),
  .INT_W    (INT_W),
  .FRAC_W   (FRAC_W)
) u_chk (
  .ref_clk    (ref_clk),
  .dith_clk   (dith_clk),
  .rst_n      (rst_n),
  .acq_en     (acq_en),
  .fine_valid (fine_valid),
  .fine_ready (fine_ready),
  .coarse_sel (coarse_sel),
  .fine_therm (fine_therm),
  .fast_word  (fast_word)
);

// File: tb/sim_dco_tune_ctrl.sv
module sim_dco_tune_ctrl;
  localparam int COARSE_W = 6;
  localparam int NUNITS   = 12;
  localparam int INT_W    = 4;
  localparam int FRAC_W   = 4;
  localparam int FINE_W   = INT_W + FRAC_W;
  localparam int PERIOD   = 1 << FRAC_W;

  logic                dith_clk = 1'b0;
  logic                ref_clk  = 1'b0;
  logic                rst_n    = 1'b0;
  logic                acq_en   = 1'b0;
  logic [COARSE_W-1:0] coarse_word = '0;
  logic [FINE_W-1:0]   fine_word   = '0;
  logic                fine_valid  = 1'b0;
  logic                fine_ready;
  logic [COARSE_W-1:0] coarse_sel;
  logic [NUNITS-1:0]   fine_therm;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  always #10 dith_clk = ~dith_clk;            // 50 MHz dither clock
  initial begin #3; forever #40 ref_clk = ~ref_clk; end  // reference at one quarter

  dco_tune_ctrl #(.COARSE_W(COARSE_W), .NUNITS(NUNITS), .INT_W(INT_W), .FRAC_W(FRAC_W)) u0 (
    .ref_clk(ref_clk), .dith_clk(dith_clk), .rst_n(rst_n), .acq_en(acq_en),
    .coarse_word(coarse_word), .fine_word(fine_word), .fine_valid(fine_valid),
    .fine_ready(fine_ready), .coarse_sel(coarse_sel), .fine_therm(fine_therm));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int clip(input int v);
    return (v > NUNITS) ? NUNITS : v;
  endfunction

  task automatic t_reset;
    #5;
    chk(coarse_sel == '0, "R1 coarse", int'(coarse_sel), 0);
    chk(fine_therm == '0, "R1 therm", int'(fine_therm), 0);
    chk(fine_ready == 1'b1, "R1 ready", int'(fine_ready), 1);
    #200 rst_n = 1'b1;
    @(negedge ref_clk);
    chk(coarse_sel == '0 && fine_ready, "R1 after release", int'(coarse_sel), 0);
  endtask

  task automatic t_coarse_acq(input logic [COARSE_W-1:0] v);
    @(negedge ref_clk);
    acq_en = 1'b1; coarse_word = v;
    @(negedge ref_clk);
    chk(coarse_sel == v, "R2 coarse capture", int'(coarse_sel), int'(v));
  endtask

  task automatic t_coarse_frozen(input logic [COARSE_W-1:0] v);
    logic [COARSE_W-1:0] keep;
    @(negedge ref_clk);
    keep = coarse_sel;
    acq_en = 1'b0; coarse_word = v;
    repeat (4) @(negedge ref_clk);
    chk(coarse_sel == keep, "R3 coarse frozen", int'(coarse_sel), int'(keep));
  endtask

  // hand a fine word over and wait until the dither domain holds it
  task automatic send_fine(input int ip, input int fr);
    int waited;
    @(negedge ref_clk);
    while (!fine_ready) @(negedge ref_clk);
    fine_word  = FINE_W'((ip << FRAC_W) | fr);
    fine_valid = 1'b1;
    @(negedge ref_clk);
    fine_valid = 1'b0;
    chk(fine_ready == 1'b0, "R4 ready low after accept", int'(fine_ready), 0);
    waited = 0;
    while (!fine_ready && waited < 20) begin
      @(negedge ref_clk);
      waited++;
    end
    chk(fine_ready == 1'b1, "R4 ready returns", int'(fine_ready), 1);
    repeat (2) @(negedge dith_clk);  // R9: two dither edges to reach the pins
  endtask

  task automatic measure(input int ip, input int fr, input string tag);
    int sum, lo, hi, pc, exp_sum;
    bit shape_ok, range_ok;
    lo = clip(ip); hi = clip(ip + ((fr != 0) ? 1 : 0));
    sum = 0; shape_ok = 1'b1; range_ok = 1'b1;
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge dith_clk);
      pc = $countones(fine_therm);
      sum += pc;
      if (((({1'b0, fine_therm} + 1'b1) & {1'b0, fine_therm})) != '0) shape_ok = 1'b0;
      if (pc != lo && pc != hi) range_ok = 1'b0;
    end
    exp_sum = fr * clip(ip + 1) + (PERIOD - fr) * clip(ip);
    chk(shape_ok, {"R5 thermometer ", tag}, int'(fine_therm), 0);
    chk(range_ok, {"R7 per-cycle count ", tag}, pc, lo);
    chk(sum == exp_sum, {"R7 R9 window sum ", tag}, sum, exp_sum);
  endtask

  task automatic t_fine(input int ip, input int fr, input string tag);
    send_fine(ip, fr);
    measure(ip, fr, tag);
  endtask

  task automatic t_int_only(input int ip);
    send_fine(ip, 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge dith_clk);
      chk($countones(fine_therm) == clip(ip), "R6 integer only",
          $countones(fine_therm), clip(ip));
    end
  endtask

  task automatic t_saturate(input int ip, input int fr);
    send_fine(ip, fr);
    for (int k = 0; k < PERIOD; k++) begin
      @(negedge dith_clk);
      if (!(&fine_therm)) begin
        chk(1'b0, "R8 saturation", int'(fine_therm), (1 << NUNITS) - 1);
        break;
      end
    end
    chk(&fine_therm, "R8 saturation end", int'(fine_therm), (1 << NUNITS) - 1);
  endtask

  task automatic t_same_edge;
    @(negedge ref_clk);
    while (!fine_ready) @(negedge ref_clk);
    acq_en = 1'b1; coarse_word = 6'h2D;
    fine_word = FINE_W'((6 << FRAC_W) | 11); fine_valid = 1'b1;
    @(negedge ref_clk);
    fine_valid = 1'b0; acq_en = 1'b0;
    chk(coarse_sel == 6'h2D, "R2 coarse with fine accept", int'(coarse_sel), 'h2D);
    chk(fine_ready == 1'b0, "R4 accept with coarse update", int'(fine_ready), 0);
    while (!fine_ready) @(negedge ref_clk);
    repeat (2) @(negedge dith_clk);
    measure(6, 11, "same edge");
    chk(coarse_sel == 6'h2D, "R3 coarse held after", int'(coarse_sel), 'h2D);
  endtask

  initial begin
    t_reset();
    t_coarse_acq(6'h2A);
    t_coarse_acq(6'h15);
    t_coarse_frozen(6'h3F);
    t_int_only(5);
    t_fine(3, 5, "3+5/16");
    t_fine(7, 15, "7+15/16");
    t_fine(0, 1, "0+1/16");
    t_fine(11, 8, "11+8/16 top edge");
    t_saturate(12, 9);
    t_saturate(15, 3);
    t_int_only(0);
    t_same_edge();
    t_coarse_frozen(6'h00);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule